// File: doc/BRIEF.md
# MFM Sync Detector and Field Checker

This block sits behind an external data separator on the read side of a flexible disk channel. Each cycle in which `slot_vld` is high, it takes one recovered half-cell sample: a clock slot, then a data slot, alternating. It looks for the special A1 sync word, whose clock transition between data bits 3 and 4 is missing. The sync word cannot occur in normally encoded data, so a match fixes the byte boundary. From that boundary on, the block decodes each group of 16 slots as one byte. The bits of each byte arrive high-order first.

Three sync words in a row, followed by a mark byte, open a field. The mark byte FE opens an identifier field and the mark byte FB opens a data field. The block passes every field byte out with a strobe. From an identifier field it captures the cylinder, side and sector bytes. When the last EDC byte of a field arrives, it gives a verdict. The verdict is CRC-good when the 16-bit CRC register holds zero after the syncs, the mark, the body and the EDC have all been shifted through it. For identifier fields, the verdict also carries a separate format-error flag for field values out of range.

Top module: `mfm_sync_field_checker`

## Requirements
- R1: After reset, and while reset is held, `locked`, `mark_stb`, `dat_stb`, `fld_done`, `crc_good`, `crc_bad` and `fmt_err` are low, `mark_kind` is 0, and `id_cyl`, `id_side` and `id_sec` are 0.
- R2: The 16 valid slots 0x4489 (clock slot first, most significant slot first) set `locked` one cycle after the last slot and restart byte alignment. The next bytes then complete exactly every 16 valid slots after the match, whatever slot phase the stream had before it.
- R3: A decoded byte takes its bits from the data slot of each pair (the second slot), high-order bit first. Clock slots are not used except in the sync match.
- R4: A byte FE that follows exactly three consecutive sync words pulses `mark_stb` one cycle after its last slot, with `mark_kind` = 1. A byte FB in the same place pulses `mark_stb` with `mark_kind` = 2.
- R5: Each of the following returns the block to hunting, with no mark, no verdict and no error flag: any other byte after three sync words, or a non-sync byte after only one or two sync words.
- R6: An identifier field has 6 bytes after the mark: cylinder, side, sector, a fixed tag, and two EDC bytes. Each byte pulses `dat_stb`. On the sixth byte, `fld_done` pulses with `fld_is_data` = 0, `id_cyl`, `id_side` and `id_sec` take the received values, and `locked` falls.
- R7: A data field has DATA_LEN body bytes plus 2 EDC bytes after the mark, each one pulsing `dat_stb`. On the last byte, `fld_done` pulses with `fld_is_data` = 1.
- R8: The CRC uses the polynomial x^16+x^12+x^5+1. It is preset to all ones at the first sync word and shifted, high bit first, through the three sync bytes (A1), the mark, the body and both EDC bytes. With `fld_done`, exactly one of `crc_good` (the final register is zero) or `crc_bad` (it is not) pulses.
- R9: For an identifier field, `fmt_err` pulses with `fld_done` when any of these holds: the tag is not 02, the side is above 1, the cylinder is above 79, or the sector is 0 or above 15. The flag does not depend on the CRC verdict and is never raised for data fields.
- R10: A sync match inside a field abandons that field without a verdict and starts a new sync count at one.
- R11: A fourth consecutive sync word counts as a new first one, so four sync words followed by FE give no mark.
- R12: Cycles with `slot_vld` low have no effect. Gaps in the stream change neither alignment nor decoded values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_vld | input | 1 | A half-cell sample is present |
| slot_bit | input | 1 | Half-cell sample value (1 = flux transition) |
| locked | output | 1 | Aligned: inside a sync run or a field |
| mark_stb | output | 1 | Mark accepted |
| mark_kind | output | 2 | Last accepted mark: 0 none, 1 identifier, 2 data |
| dat_stb | output | 1 | Field byte valid |
| dat_byte | output | 8 | Field byte, EDC bytes included |
| fld_done | output | 1 | Field complete, verdict valid |
| fld_is_data | output | 1 | The completed field was a data field |
| crc_good | output | 1 | CRC residue zero (with `fld_done`) |
| crc_bad | output | 1 | CRC residue non-zero (with `fld_done`) |
| fmt_err | output | 1 | Identifier value out of range (with `fld_done`) |
| id_cyl | output | 8 | Last captured cylinder |
| id_side | output | 8 | Last captured side |
| id_sec | output | 8 | Last captured sector |

## Verification
A slot counter off by one shows up as garbled `dat_byte` values from the first byte after a sync, and no mark is then accepted. A sync counter that is wrong either accepts marks after short runs or refuses them after good runs, and this is visible on the next `mark_stb`. A CRC register that is preset or fed wrongly stays hidden until the field ends, when it shows as `crc_bad` instead of `crc_good`. A field length counter that is wrong shifts `fld_done` away from the last EDC byte, or suppresses it.

// File: rtl/mfm_sync_pkg.sv
package mfm_sync_pkg;

  localparam logic [15:0] SYNC_SLOTS = 16'h4489;
  localparam logic [7:0]  SYNC_BYTE  = 8'hA1;
  localparam logic [7:0]  MARK_ID    = 8'hFE;
  localparam logic [7:0]  MARK_DATA  = 8'hFB;
  localparam logic [7:0]  ID_TAG     = 8'h02;
  localparam logic [15:0] CRC_POLY   = 16'h1021;
  localparam logic [15:0] CRC_PRESET = 16'hFFFF;

  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_SYNC = 2'd1,
    ST_ID   = 2'd2,
    ST_DATA = 2'd3
  } det_state_e;

  typedef enum logic [1:0] {
    MK_NONE = 2'd0,
    MK_ID   = 2'd1,
    MK_DATA = 2'd2
  } mark_kind_e;

  // Whole-byte CRC update, byte folded into the high half first.
  function automatic logic [15:0] crc16_step(input logic [15:0] crc, input logic [7:0] b);
    logic [15:0] c;
    c = crc ^ {b, 8'h00};
    for (int i = 0; i < 8; i++) begin
      c = c[15] ? ({c[14:0], 1'b0} ^ CRC_POLY) : {c[14:0], 1'b0};
    end
    return c;
  endfunction

  // Data slots are the even positions of a clock/data slot word.
  function automatic logic [7:0] slot_data_bits(input logic [15:0] slots);
    logic [7:0] d;
    for (int i = 0; i < 8; i++) begin
      d[i] = slots[2*i];
    end
    return d;
  endfunction

  function automatic logic id_out_of_range(input logic [7:0] cyl, input logic [7:0] side,
                                           input logic [7:0] sec, input logic [7:0] tag,
                                           input logic [7:0] max_cyl, input logic [7:0] max_sec);
    return (tag != ID_TAG) || (side > 8'd1) || (cyl > max_cyl) ||
           (sec == 8'd0) || (sec > max_sec);
  endfunction

endpackage

// File: rtl/mfm_slot_aligner.sv
module mfm_slot_aligner
  import mfm_sync_pkg::*;
#(
  parameter int SLOTS_PER_BYTE = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       slot_vld,
  input  logic       slot_bit,
  output logic       sync_hit,
  output logic       byte_rdy,
  output logic [7:0] byte_val
);
  localparam int CW = $clog2(SLOTS_PER_BYTE);
  localparam logic [CW-1:0] LAST_SLOT = CW'(SLOTS_PER_BYTE - 1);

  logic [15:0]   shreg;
  logic [15:0]   shreg_nxt;
  logic [CW-1:0] phase;
  logic          aligned;

  assign shreg_nxt = {shreg[14:0], slot_bit};
  assign sync_hit  = slot_vld && (shreg_nxt == SYNC_SLOTS);
  assign byte_rdy  = slot_vld && !sync_hit && aligned && (phase == LAST_SLOT);
  assign byte_val  = slot_data_bits(shreg_nxt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      phase   <= '0;
      aligned <= 1'b0;
    end else if (slot_vld) begin
      shreg <= shreg_nxt;
      if (sync_hit) begin
        phase   <= '0;
        aligned <= 1'b1;
      end else begin
        phase <= phase + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mfm_crc_unit.sv
module mfm_crc_unit
  import mfm_sync_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       feed,
  input  logic [7:0] din,
  output logic       zero_after
);
  logic [15:0] crc_q;
  logic [15:0] base;
  logic [15:0] crc_nxt;

  assign base       = start ? CRC_PRESET : crc_q;
  assign crc_nxt    = crc16_step(base, din);
  assign zero_after = (crc_nxt == 16'h0000);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= CRC_PRESET;
    end else if (start || feed) begin
      crc_q <= crc_nxt;
    end
  end
endmodule

// File: rtl/mfm_field_fsm.sv
module mfm_field_fsm
  import mfm_sync_pkg::*;
#(
  parameter int DATA_LEN   = 512,
  parameter int ID_LEN     = 4,
  parameter int EDC_LEN    = 2,
  parameter int SYNC_COUNT = 3,
  parameter int MAX_CYL    = 79,
  parameter int MAX_SEC    = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sync_hit,
  input  logic       byte_rdy,
  input  logic [7:0] byte_val,
  input  logic       crc_zero,
  output logic       crc_start,
  output logic       crc_feed,
  output logic [7:0] crc_din,
  output logic       locked,
  output logic       mark_stb,
  output logic [1:0] mark_kind,
  output logic       dat_stb,
  output logic [7:0] dat_byte,
  output logic       fld_done,
  output logic       fld_is_data,
  output logic       crc_good,
  output logic       crc_bad,
  output logic       fmt_err,
  output logic [7:0] id_cyl,
  output logic [7:0] id_side,
  output logic [7:0] id_sec
);
  localparam int ID_TOTAL   = ID_LEN + EDC_LEN;
  localparam int DATA_TOTAL = DATA_LEN + EDC_LEN;
  localparam int IW         = $clog2(DATA_TOTAL + 1);
  localparam logic [IW-1:0] ID_LAST   = IW'(ID_TOTAL - 1);
  localparam logic [IW-1:0] DATA_LAST = IW'(DATA_TOTAL - 1);
  localparam logic [1:0]    SYNC_FULL = 2'(SYNC_COUNT);

  det_state_e    state;
  logic [1:0]    a1_cnt;
  logic [IW-1:0] idx;
  logic [7:0]    sh_cyl, sh_side, sh_sec, sh_tag;
  logic          last_byte;
  logic          run_open;

  assign run_open  = (state == ST_SYNC) && (a1_cnt != SYNC_FULL);
  assign last_byte = ((state == ST_ID) && (idx == ID_LAST)) ||
                     ((state == ST_DATA) && (idx == DATA_LAST));

  always_comb begin
    crc_start = sync_hit && !run_open;
    crc_feed  = (sync_hit && run_open) || (byte_rdy && (state != ST_HUNT));
    crc_din   = sync_hit ? SYNC_BYTE : byte_val;
  end

  assign locked = (state != ST_HUNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_HUNT;
      a1_cnt      <= '0;
      idx         <= '0;
      mark_stb    <= 1'b0;
      mark_kind   <= MK_NONE;
      dat_stb     <= 1'b0;
      dat_byte    <= '0;
      fld_done    <= 1'b0;
      fld_is_data <= 1'b0;
      crc_good    <= 1'b0;
      crc_bad     <= 1'b0;
      fmt_err     <= 1'b0;
      sh_cyl      <= '0;
      sh_side     <= '0;
      sh_sec      <= '0;
      sh_tag      <= '0;
      id_cyl      <= '0;
      id_side     <= '0;
      id_sec      <= '0;
    end else begin
      mark_stb <= 1'b0;
      dat_stb  <= 1'b0;
      fld_done <= 1'b0;
      crc_good <= 1'b0;
      crc_bad  <= 1'b0;
      fmt_err  <= 1'b0;
      if (sync_hit) begin
        state  <= ST_SYNC;
        a1_cnt <= run_open ? a1_cnt + 2'd1 : 2'd1;
      end else if (byte_rdy) begin
        unique case (state)
          ST_HUNT: ;
          ST_SYNC: begin
            idx <= '0;
            if (a1_cnt == SYNC_FULL && byte_val == MARK_ID) begin
              state     <= ST_ID;
              mark_stb  <= 1'b1;
              mark_kind <= MK_ID;
            end else if (a1_cnt == SYNC_FULL && byte_val == MARK_DATA) begin
              state     <= ST_DATA;
              mark_stb  <= 1'b1;
              mark_kind <= MK_DATA;
            end else begin
              state <= ST_HUNT;
            end
          end
          ST_ID, ST_DATA: begin
            dat_stb  <= 1'b1;
            dat_byte <= byte_val;
            idx      <= idx + 1'b1;
            if (state == ST_ID) begin
              if (idx == IW'(0)) sh_cyl  <= byte_val;
              if (idx == IW'(1)) sh_side <= byte_val;
              if (idx == IW'(2)) sh_sec  <= byte_val;
              if (idx == IW'(3)) sh_tag  <= byte_val;
            end
            if (last_byte) begin
              state       <= ST_HUNT;
              fld_done    <= 1'b1;
              fld_is_data <= (state == ST_DATA);
              crc_good    <= crc_zero;
              crc_bad     <= !crc_zero;
              if (state == ST_ID) begin
                fmt_err <= id_out_of_range(sh_cyl, sh_side, sh_sec, sh_tag,
                                           8'(MAX_CYL), 8'(MAX_SEC));
                id_cyl  <= sh_cyl;
                id_side <= sh_side;
                id_sec  <= sh_sec;
              end
            end
          end
          default: state <= ST_HUNT;
        endcase
      end
    end
  end
endmodule

// File: rtl/mfm_sync_field_checker.sv
module mfm_sync_field_checker
  import mfm_sync_pkg::*;
#(
  parameter int DATA_LEN = 512,
  parameter int MAX_CYL  = 79,
  parameter int MAX_SEC  = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       slot_vld,
  input  logic       slot_bit,
  output logic       locked,
  output logic       mark_stb,
  output logic [1:0] mark_kind,
  output logic       dat_stb,
  output logic [7:0] dat_byte,
  output logic       fld_done,
  output logic       fld_is_data,
  output logic       crc_good,
  output logic       crc_bad,
  output logic       fmt_err,
  output logic [7:0] id_cyl,
  output logic [7:0] id_side,
  output logic [7:0] id_sec
);
  logic       sync_hit;
  logic       byte_rdy;
  logic [7:0] byte_val;
  logic       crc_start;
  logic       crc_feed;
  logic [7:0] crc_din;
  logic       crc_zero;

  mfm_slot_aligner #(.SLOTS_PER_BYTE(16)) u_align (
    .clk      (clk),
    .rst_n    (rst_n),
    .slot_vld (slot_vld),
    .slot_bit (slot_bit),
    .sync_hit (sync_hit),
    .byte_rdy (byte_rdy),
    .byte_val (byte_val)
  );

  mfm_crc_unit u_crc (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (crc_start),
    .feed       (crc_feed),
    .din        (crc_din),
    .zero_after (crc_zero)
  );

  mfm_field_fsm #(
    .DATA_LEN (DATA_LEN),
    .MAX_CYL  (MAX_CYL),
    .MAX_SEC  (MAX_SEC)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .sync_hit    (sync_hit),
    .byte_rdy    (byte_rdy),
    .byte_val    (byte_val),
    .crc_zero    (crc_zero),
    .crc_start   (crc_start),
    .crc_feed    (crc_feed),
    .crc_din     (crc_din),
    .locked      (locked),
    .mark_stb    (mark_stb),
    .mark_kind   (mark_kind),
    .dat_stb     (dat_stb),
    .dat_byte    (dat_byte),
    .fld_done    (fld_done),
    .fld_is_data (fld_is_data),
    .crc_good    (crc_good),
    .crc_bad     (crc_bad),
    .fmt_err     (fmt_err),
    .id_cyl      (id_cyl),
    .id_side     (id_side),
    .id_sec      (id_sec)
  );
endmodule

// File: rtl/mfm_sync_field_checker_sva.sv
module mfm_sync_field_checker_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       sync_hit,
  input logic       byte_rdy,
  input logic       locked,
  input logic       mark_stb,
  input logic [1:0] mark_kind,
  input logic       dat_stb,
  input logic       fld_done,
  input logic       fld_is_data,
  input logic       crc_good,
  input logic       crc_bad,
  input logic       fmt_err
);
  p_hit_locks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sync_hit |=> (locked && !mark_stb && !fld_done && !dat_stb));

  p_mark_from_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mark_stb |-> ($past(byte_rdy) && mark_kind != 2'd0));

  p_dat_from_byte_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dat_stb |-> $past(byte_rdy));

  p_done_unlocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fld_done |-> !locked);

  p_one_verdict_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fld_done |-> $onehot({crc_good, crc_bad}));

  p_no_stray_verdict_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !fld_done |-> !(crc_good || crc_bad || fmt_err));

  p_fmt_id_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_err |-> !fld_is_data);
endmodule

bind mfm_sync_field_checker mfm_sync_field_checker_sva u_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .sync_hit    (sync_hit),
  .byte_rdy    (byte_rdy),
  .locked      (locked),
  .mark_stb    (mark_stb),
  .mark_kind   (mark_kind),
  .dat_stb     (dat_stb),
  .fld_done    (fld_done),
  .fld_is_data (fld_is_data),
  .crc_good    (crc_good),
  .crc_bad     (crc_bad),
  .fmt_err     (fmt_err)
);

// File: tb/mfm_sync_field_checker_tb_top.sv
module mfm_sync_field_checker_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n;
  logic       slot_vld;
  logic       slot_bit;
  logic       locked, mark_stb, dat_stb, fld_done, fld_is_data;
  logic       crc_good, crc_bad, fmt_err;
  logic [1:0] mark_kind;
  logic [7:0] dat_byte, id_cyl, id_side, id_sec;

  mfm_sync_field_checker dut_i (
    .clk(clk), .rst_n(rst_n), .slot_vld(slot_vld), .slot_bit(slot_bit),
    .locked(locked), .mark_stb(mark_stb), .mark_kind(mark_kind),
    .dat_stb(dat_stb), .dat_byte(dat_byte), .fld_done(fld_done),
    .fld_is_data(fld_is_data), .crc_good(crc_good), .crc_bad(crc_bad),
    .fmt_err(fmt_err), .id_cyl(id_cyl), .id_side(id_side), .id_sec(id_sec)
  );

  // {cyl, side, sec, tag, 5'b0, corrupt, exp_good, exp_fmt}
  localparam logic [39:0] ID_VEC [8] = '{
    {8'd0,  8'd0, 8'd1,  8'h02, 5'd0, 1'b0, 1'b1, 1'b0},
    {8'd79, 8'd1, 8'd15, 8'h02, 5'd0, 1'b0, 1'b1, 1'b0},
    {8'd80, 8'd0, 8'd1,  8'h02, 5'd0, 1'b0, 1'b1, 1'b1},
    {8'd5,  8'd2, 8'd3,  8'h02, 5'd0, 1'b0, 1'b1, 1'b1},
    {8'd5,  8'd1, 8'd0,  8'h02, 5'd0, 1'b0, 1'b1, 1'b1},
    {8'd5,  8'd1, 8'd16, 8'h02, 5'd0, 1'b0, 1'b1, 1'b1},
    {8'd5,  8'd0, 8'd7,  8'h03, 5'd0, 1'b0, 1'b1, 1'b1},
    {8'd40, 8'd1, 8'd9,  8'h02, 5'd0, 1'b1, 1'b0, 1'b0}
  };

  int total = 0;
  int bad = 0;
  bit finished = 0;
  bit prev_d = 0;
  bit gap_on = 0;
  int slot_n = 0;
  logic [7:0] pay [514];

  int n_mark = 0, n_done = 0, n_dat = 0, n_good = 0, n_badc = 0, n_fmt = 0;
  logic [1:0] last_kind = 2'd0;
  logic       last_is_data = 1'b0;
  logic [7:0] first_dat = 8'h00;
  bit         want_first = 0;

  always @(negedge clk) begin
    if (mark_stb) begin
      n_mark++;
      last_kind = mark_kind;
      want_first = 1;
    end
    if (dat_stb) begin
      n_dat++;
      if (want_first) begin
        first_dat = dat_byte;
        want_first = 0;
      end
    end
    if (fld_done) begin
      n_done++;
      last_is_data = fld_is_data;
      if (crc_good) n_good++;
      if (crc_bad) n_badc++;
      if (fmt_err) n_fmt++;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Serial CRC, one bit at a time with feedback from the top stage.
  function automatic logic [15:0] tb_crc(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r = c;
    for (int i = 7; i >= 0; i--) begin
      logic fb = r[15] ^ b[i];
      r = {r[14:0], 1'b0};
      if (fb) r = r ^ 16'h1021;
    end
    return r;
  endfunction

  task automatic put_slot(input bit b);
    @(negedge clk);
    slot_vld = 1'b1;
    slot_bit = b;
    slot_n++;
    if (gap_on && (slot_n % 5 == 0)) begin
      @(negedge clk);
      slot_vld = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      slot_vld = 1'b0;
    end
  endtask

  task automatic put_word(input logic [15:0] w);
    for (int i = 15; i >= 0; i--) put_slot(w[i]);
  endtask

  task automatic put_byte(input logic [7:0] b);
    logic [15:0] w;
    for (int i = 7; i >= 0; i--) begin
      w[2*i+1] = !(prev_d | b[i]);
      w[2*i]   = b[i];
      prev_d   = b[i];
    end
    put_word(w);
  endtask

  task automatic put_sync();
    put_word(16'h4489);
    prev_d = 1'b1;
  endtask

  task automatic send_rec(input logic [7:0] mark, input int n, input bit corrupt, input bit pre);
    logic [15:0] c = 16'hFFFF;
    if (pre) repeat (12) put_byte(8'h00);
    repeat (3) begin
      put_sync();
      c = tb_crc(c, 8'hA1);
    end
    put_byte(mark);
    c = tb_crc(c, mark);
    for (int i = 0; i < n; i++) begin
      put_byte(pay[i]);
      c = tb_crc(c, pay[i]);
    end
    c = c ^ {15'd0, corrupt};
    put_byte(c[15:8]);
    put_byte(c[7:0]);
    idle(3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int m0, d0, t0, g0, b0, f0;
    rst_n = 1'b0;
    slot_vld = 1'b0;
    slot_bit = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!locked && !mark_stb && !dat_stb && !fld_done && !crc_good && !crc_bad && !fmt_err,
        "R1 strobes in reset", {locked, mark_stb, dat_stb, fld_done}, 0);
    chk(mark_kind == 0 && id_cyl == 0 && id_side == 0 && id_sec == 0,
        "R1 held outputs in reset", {mark_kind, id_cyl, id_side, id_sec}, 0);
    rst_n = 1'b1;
    idle(2);

    // Identifier vector table: R2, R4, R6, R8, R9, R12
    for (int v = 0; v < 8; v++) begin
      logic [39:0] e = ID_VEC[v];
      gap_on = v[0];
      if (v == 2 || v == 5) put_slot(1'b0);   // R2: shift the slot phase
      pay[0] = e[39:32]; pay[1] = e[31:24]; pay[2] = e[23:16]; pay[3] = e[15:8];
      m0 = n_mark; d0 = n_done; t0 = n_dat; g0 = n_good; b0 = n_badc; f0 = n_fmt;
      send_rec(8'hFE, 4, e[2], 1'b1);
      chk(n_mark == m0 + 1 && last_kind == 2'd1, $sformatf("R4 id mark v%0d", v), last_kind, 1);
      chk(n_dat == t0 + 6, $sformatf("R6 id bytes v%0d R2 R12", v), n_dat - t0, 6);
      chk(n_done == d0 + 1 && !last_is_data, $sformatf("R6 id done v%0d", v), n_done - d0, 1);
      chk((n_good - g0) == int'(e[1]) && (n_badc - b0) == int'(!e[1]),
          $sformatf("R8 id crc v%0d", v), n_good - g0, e[1]);
      chk((n_fmt - f0) == int'(e[0]), $sformatf("R9 fmt v%0d", v), n_fmt - f0, e[0]);
      chk(id_cyl == e[39:32] && id_side == e[31:24] && id_sec == e[23:16],
          $sformatf("R6 id capture v%0d", v), {id_cyl, id_side, id_sec}, e[39:16]);
      chk(!locked, $sformatf("R6 unlock v%0d", v), locked, 0);
    end
    gap_on = 1'b0;

    // R7, R3, R8: good data field
    for (int i = 0; i < 512; i++) pay[i] = 8'(i * 7 + 3);
    m0 = n_mark; d0 = n_done; t0 = n_dat; g0 = n_good; f0 = n_fmt;
    send_rec(8'hFB, 512, 1'b0, 1'b1);
    chk(n_mark == m0 + 1 && last_kind == 2'd2, "R4 data mark", last_kind, 2);
    chk(n_dat == t0 + 514, "R7 data byte count", n_dat - t0, 514);
    chk(n_done == d0 + 1 && last_is_data, "R7 data done", last_is_data, 1);
    chk(n_good == g0 + 1 && n_fmt == f0, "R8 data crc good", n_good - g0, 1);
    chk(first_dat == 8'h03, "R3 first data byte", first_dat, 8'h03);

    // R8: corrupted data field, with gaps (R12)
    gap_on = 1'b1;
    b0 = n_badc; g0 = n_good;
    send_rec(8'hFB, 512, 1'b1, 1'b1);
    chk(n_badc == b0 + 1 && n_good == g0, "R8 data crc bad R12", n_badc - b0, 1);
    gap_on = 1'b0;

    // R5: two syncs then FE
    m0 = n_mark; d0 = n_done;
    repeat (12) put_byte(8'h00);
    repeat (2) put_sync();
    put_byte(8'hFE);
    repeat (8) put_byte(8'h11);
    idle(3);
    chk(n_mark == m0 && n_done == d0 && !locked, "R5 short sync run", n_mark - m0, 0);

    // R5: three syncs then an unknown mark
    repeat (12) put_byte(8'h00);
    repeat (3) put_sync();
    put_byte(8'h55);
    repeat (8) put_byte(8'h22);
    idle(3);
    chk(n_mark == m0 && n_done == d0 && !locked, "R5 unknown mark", n_mark - m0, 0);

    // R11: four syncs then FE
    repeat (12) put_byte(8'h00);
    repeat (4) put_sync();
    put_byte(8'hFE);
    repeat (8) put_byte(8'h00);
    idle(3);
    chk(n_mark == m0 && n_done == d0, "R11 fourth sync restarts count", n_mark - m0, 0);

    // R10: sync inside an identifier field abandons it
    m0 = n_mark; d0 = n_done; g0 = n_good;
    repeat (12) put_byte(8'h00);
    repeat (3) put_sync();
    put_byte(8'hFE);
    put_byte(8'd9);
    put_byte(8'd1);
    pay[0] = 8'd33; pay[1] = 8'd0; pay[2] = 8'd4; pay[3] = 8'h02;
    send_rec(8'hFE, 4, 1'b0, 1'b0);
    chk(n_mark == m0 + 2 && n_done == d0 + 1 && n_good == g0 + 1,
        "R10 abandoned field", n_done - d0, 1);
    chk(id_cyl == 8'd33 && id_sec == 8'd4, "R10 capture from new field", id_cyl, 33);

    // R1: reset in the middle of a data field
    repeat (12) put_byte(8'h00);
    repeat (3) put_sync();
    put_byte(8'hFB);
    repeat (5) put_byte(8'h77);
    @(negedge clk);
    slot_vld = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk(!locked && mark_kind == 0 && id_cyl == 0 && !dat_stb, "R1 reset mid field",
        {locked, mark_kind, id_cyl}, 0);
    rst_n = 1'b1;
    idle(2);
    d0 = n_done; g0 = n_good;
    pay[0] = 8'd12; pay[1] = 8'd1; pay[2] = 8'd2; pay[3] = 8'h02;
    send_rec(8'hFE, 4, 1'b0, 1'b1);
    chk(n_done == d0 + 1 && n_good == g0 + 1 && id_side == 8'd1, "R6 R8 after reset",
        n_done - d0, 1);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule